// File: doc/BRIEF.md
# Slow-Clock Phase Reference and Update Strobe

This block lives in a fast clock domain and rebuilds, as an ordinary registered signal, the waveform of a related slower clock. The slower clock reaches it as a copy shifted by a quarter period. Sampling that shifted copy gives a register image that is aligned in phase with the real slow clock. The image is never used as a clock. It only serves as a phase reference for the fast logic.

From that image the block derives a one-cycle update strobe on a chosen edge of the image, falling by default. Its own output register, which feeds the slow domain, loads new data only in that cycle. Interface flip-flops therefore change well away from the slow domain's active edge. The ratio of fast to slow clock may be any integer of 2 or more, and a parameter selects which edge of the image marks the update cycle.

Top module: `slowref_top`

## Requirements
- R1: While reset is sampled high on a fast clock edge, the registered copy, the update strobe and the data output all read 0 after that edge.
- R2: The registered copy equals the value of the shifted slow input as sampled two fast clock edges earlier, through two flip-flops in series.
- R3: With the edge selector at falling (EDGE_SEL = EDGE_FALL, encoding 0), the update strobe is high in exactly the fast cycle in which the copy first reads 0 after having read 1, and low in every other cycle.
- R4: With the edge selector at rising (EDGE_SEL = EDGE_RISE, encoding 1), the update strobe is high in exactly the fast cycle in which the copy first reads 1 after having read 0, and low in every other cycle.
- R5: The update strobe is never high in two consecutive fast cycles, and it pulses exactly once for each slow clock period.
- R6: On a fast edge where the update strobe is high, the data output takes the value of the data input, and the new value is visible after that edge.
- R7: Changes on the data input while the update strobe is low have no effect on the data output.
- R8: R2 through R6 hold for every integer ratio of fast to slow clock of 2 or more, including ratio 2 and odd ratios with any split between high and low time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock |
| rst_i | input | 1 | Synchronous active-high reset |
| slow90_i | input | 1 | Slow clock shifted by a quarter period |
| data_i | input | DATA_W | Data to hand to the slow domain |
| slow_copy_o | output | 1 | Registered copy of the slow clock |
| upd_en_o | output | 1 | One-cycle update strobe |
| data_o | output | DATA_W | Interface output register |

## Verification
Several properties are checked on every fast cycle by assertions: the two-cycle lag of the copy behind the input, the level of the copy whenever the strobe fires, the ban on back-to-back strobes, and the load-or-hold rule of the output register. What only the bench scenarios can show is that exactly one strobe appears per slow period across different ratios and duty splits, including the ratio-2 extreme. The scenarios also show that both edge selections place the strobe in the right cycle, and that a reset in the middle of a run clears everything.

// File: rtl/slowref_pkg.sv
package slowref_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } phase_pair_t;

    // Edge found between two consecutive samples of the copy
    function automatic logic edge_hit(edge_sel_e sel, phase_pair_t p);
        if (sel == EDGE_FALL) return p.prev & ~p.cur;
        else                  return ~p.prev & p.cur;
    endfunction

endpackage

// File: rtl/slowref_sync.sv
module slowref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic slow_i,
    output logic copy_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk_i) begin
        if (rst_i) chain <= '0;
        else       chain <= {chain[STAGES-2:0], slow_i};
    end

    assign copy_o = chain[STAGES-1];

endmodule

// File: rtl/slowref_edge.sv
module slowref_edge
    import slowref_pkg::*;
#(
    parameter edge_sel_e EDGE_SEL = EDGE_FALL
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic copy_i,
    output logic en_o
);
    phase_pair_t pair;
    logic        prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= copy_i;
    end

    assign pair.cur  = copy_i;
    assign pair.prev = prev_q;

    generate
        if (EDGE_SEL == EDGE_FALL) begin : g_fall
            assign en_o = edge_hit(EDGE_FALL, pair);
            assert_fall_level_R3: assert property (@(posedge clk_i) disable iff (rst_i)
                en_o |-> (!copy_i && $past(copy_i)));
        end else begin : g_rise
            assign en_o = edge_hit(EDGE_RISE, pair);
            assert_rise_level_R4: assert property (@(posedge clk_i) disable iff (rst_i)
                en_o |-> (copy_i && !$past(copy_i)));
        end
    endgenerate

    assert_no_double_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        en_o |=> !en_o);

endmodule

// File: rtl/slowref_hold.sv
module slowref_hold #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)     q_o <= '0;
        else if (en_i) q_o <= d_i;
    end

    assert_load_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(en_i) && !$past(rst_i)) |-> (q_o == $past(d_i)));

    assert_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(en_i) && !$past(rst_i)) |-> $stable(q_o));

endmodule

// File: rtl/slowref_top.sv
module slowref_top
    import slowref_pkg::*;
#(
    parameter int        DATA_W      = 8,
    parameter int        SYNC_STAGES = 2,
    parameter edge_sel_e EDGE_SEL    = EDGE_FALL
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              slow90_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              slow_copy_o,
    output logic              upd_en_o,
    output logic [DATA_W-1:0] data_o
);
    logic copy_w;
    logic en_w;

    slowref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .slow_i (slow90_i),
        .copy_o (copy_w)
    );

    slowref_edge #(.EDGE_SEL(EDGE_SEL)) u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .copy_i (copy_w),
        .en_o   (en_w)
    );

    slowref_hold #(.WIDTH(DATA_W)) u_hold (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (en_w),
        .d_i   (data_i),
        .q_o   (data_o)
    );

    assign slow_copy_o = copy_w;
    assign upd_en_o    = en_w;

    generate
        if (SYNC_STAGES == 2) begin : g_lag_chk
            assert_copy_lag_R2: assert property (@(posedge clk_i) disable iff (rst_i)
                (!$past(rst_i) && !$past(rst_i, 2)) |-> (copy_w == $past(slow90_i, 2)));
        end
    endgenerate

endmodule

// File: tb/test_slowref_top.sv
module test_slowref_top;
    import slowref_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          slow = 1'b0;
    logic [DW-1:0] din = '0;

    logic          copy_f, en_f, copy_r, en_r;
    logic [DW-1:0] q_f, q_r;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model state
    logic          m1 = 0, m2 = 0, m3 = 0;
    logic [DW-1:0] mq_f = '0, mq_r = '0;
    int            pulses_f = 0, pulses_r = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slowref_top #(.DATA_W(DW), .EDGE_SEL(EDGE_FALL)) i_slowref_top (
        .clk_i(clk), .rst_i(rst), .slow90_i(slow), .data_i(din),
        .slow_copy_o(copy_f), .upd_en_o(en_f), .data_o(q_f));

    slowref_top #(.DATA_W(DW), .EDGE_SEL(EDGE_RISE)) i_slowref_top_rise (
        .clk_i(clk), .rst_i(rst), .slow90_i(slow), .data_i(din),
        .slow_copy_o(copy_r), .upd_en_o(en_r), .data_o(q_r));

    function automatic logic exp_fall();
        return m3 & ~m2;
    endfunction
    function automatic logic exp_rise();
        return ~m3 & m2;
    endfunction

    // Expected values from the requirements: copy lags input by two edges
    always @(posedge clk) begin
        if (rst) begin
            m1 <= 0; m2 <= 0; m3 <= 0; mq_f <= '0; mq_r <= '0;
        end else begin
            m1 <= slow; m2 <= m1; m3 <= m2;
            if (exp_fall()) mq_f <= din;
            if (exp_rise()) mq_r <= din;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one fast cycle: check after the previous edge, then drive new inputs
    task automatic cycle(logic s, logic [DW-1:0] d);
        @(negedge clk);
        chk("R2 copy", 32'(copy_f), 32'(m2));
        chk("R2 copy rise inst", 32'(copy_r), 32'(m2));
        chk("R3 fall strobe", 32'(en_f), 32'(exp_fall()));
        chk("R4 rise strobe", 32'(en_r), 32'(exp_rise()));
        chk("R6/R7 data fall", 32'(q_f), 32'(mq_f));
        chk("R6/R7 data rise", 32'(q_r), 32'(mq_r));
        if (en_f) pulses_f++;
        if (en_r) pulses_r++;
        slow = s;
        din  = d;
    endtask

    // R8: a slow waveform of given ratio and high time
    task automatic run_slow(int ratio, int high, int periods);
        int pf0 = pulses_f;
        int pr0 = pulses_r;
        for (int p = 0; p < periods; p++)
            for (int c = 0; c < ratio; c++)
                cycle(c < high, DW'($urandom));
        for (int k = 0; k < 4; k++) cycle(1'b0, DW'($urandom));
        chk($sformatf("R5 fall pulses ratio %0d", ratio), 32'(pulses_f - pf0), 32'(periods));
        chk($sformatf("R5 rise pulses ratio %0d", ratio), 32'(pulses_r - pr0), 32'(periods));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        slow = 1'b1; din = 8'hA5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 copy reset", 32'(copy_f), 0);
        chk("R1 strobe reset", 32'(en_f), 0);
        chk("R1 data reset", 32'(q_f), 0);
        slow = 1'b0;
        rst = 1'b0;

        // directed: R7 data wiggling with the slow input idle
        for (int k = 0; k < 6; k++) cycle(1'b0, DW'($urandom));
        chk("R7 idle data held", 32'(q_f), 0);

        // directed corners: ratio 2, odd ratios with uneven splits
        run_slow(2, 1, 10);
        run_slow(3, 1, 6);
        run_slow(3, 2, 6);
        run_slow(5, 4, 5);
        run_slow(8, 4, 5);

        // random ratios and duty splits
        for (int t = 0; t < 30; t++) begin
            int r = 2 + int'($urandom_range(0, 14));
            int h = 1 + int'($urandom_range(0, r - 2));
            run_slow(r, h, 2 + int'($urandom_range(0, 5)));
        end

        // reset in mid-run with slow input high
        cycle(1'b1, 8'h3C);
        cycle(1'b1, 8'h3C);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 copy mid reset", 32'(copy_f), 0);
        chk("R1 strobe mid reset", 32'(en_r), 0);
        chk("R1 data mid reset", 32'(q_r), 0);
        slow = 1'b0;
        rst = 1'b0;
        run_slow(4, 2, 4);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule